// File: doc/BRIEF.md
# Calibration State Watchdog

This block follows how far a CAN node's clock calibration has progressed. It keeps a three-level state: not calibrated, basic calibrated and precision calibrated. One 16-bit countdown watchdog moves the state down a level when the traffic expected at the current level stops arriving. The oscillator measurement and the frame decoding are outside the block. They appear only as strobes: a falling edge on the receive line, a message-received pulse, a quartz-node-message pulse, a tick enable for the countdown, and an init level from the protocol engine that pauses everything while it is high.

Software sees four words through a small synchronous register port:

| Address | Content |
|---|---|
| 0 | Watchdog word: reload value and live count |
| 1 | Status word: state code |
| 2 | Event flags |
| 3 | Interrupt enables |

The read data is combinational on the address. A single interrupt line combines the flags that are enabled.

Top module: `calib_watchdog`

## Requirements
- R1: The state code reads at address 1 in bits 31:30. The codes are 00 for not calibrated, 01 for basic and 10 for precision. Code 11 never occurs, and every other bit of that word reads 0.
- R2: At address 0, bits 15:0 hold the read-write reload value and bits 31:16 the read-only live count. In the not-calibrated state the count follows the reload value and does not run until a falling edge on `rx_line` arms it. A falling edge means `rx_line` is 0 in a cycle after a cycle where it was 1.
- R3: A timeout in the not-calibrated state leaves the state at 00 and reloads the count. The count then stays parked until the next falling edge.
- R4: When the watchdog is armed in the not-calibrated state, a `msg_rx` pulse moves the state to basic and restarts the count from the reload value.
- R5: In the basic state every `msg_rx` pulse restarts the count. A timeout returns the state to not calibrated and disarms the watchdog.
- R6: A `qz_rx` pulse while the watchdog is armed moves the state to precision and restarts the count. In the precision state `msg_rx` does not restart the count.
- R7: A timeout in the precision state moves the state to basic, not to not calibrated.
- R8: While `eng_init` is 1 the count, the state and the arming all hold. A falling edge seen during that time is lost.
- R9: An armed, running count decreases by one per cycle with `tick_en` high, and never wraps below zero. A timeout occurs in any cycle where the armed count is zero and no restart is present. A reload value of zero therefore times out one cycle after the count is reloaded.
- R10: The flags are at address 2: bit 0 records a timeout and bit 1 records a state change. Writing 1 to a bit clears it and writing 0 has no effect. When a new event and a clear meet in the same cycle, the event wins.
- R11: `irq` is 1 exactly while some flag bit and the enable bit at the same position of address 3 are both 1.
- R12: Reset clears the state to 00, the flags, the enables, the reload value and the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Receive line level; its falling edges arm the watchdog |
| msg_rx | input | 1 | Pulse: a message was received |
| qz_rx | input | 1 | Pulse: a message from a quartz-controlled node was received |
| eng_init | input | 1 | Protocol engine in init; 1 pauses the watchdog |
| tick_en | input | 1 | Countdown tick enable |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq | output | 1 | Interrupt: any enabled flag set |

## Verification
The hardest situations to reach are the precision-to-basic timeout and the timeout that follows a reload value of zero. Both require the watchdog to be armed by a real falling edge, then the state to be raised by the right strobe, and only then the count to be run down. The table drives one continuous story through every level, with countdowns long enough to watch each decrement. On the way it pauses the engine in the middle of a countdown and drops a falling edge while the engine is in init. It rewrites the reload value to zero just before a restart, so the immediate timeout and the second-level fall both follow from earlier steps. A directed test then lines up a timeout in the same cycle as a clear write to show that the new event wins.

// File: rtl/calw_pkg.sv
package calw_pkg;

  typedef enum logic [1:0] {
    CAL_NONE    = 2'b00,
    CAL_BASIC   = 2'b01,
    CAL_PRECISE = 2'b10
  } cal_state_e;

  localparam logic [1:0] REG_WDOG = 2'd0;
  localparam logic [1:0] REG_STAT = 2'd1;
  localparam logic [1:0] REG_FLAG = 2'd2;
  localparam logic [1:0] REG_ENAB = 2'd3;

  // Next calibration level from the qualified events of this cycle.
  function automatic cal_state_e cal_next(cal_state_e s, logic tmo, logic qz_ev,
                                          logic msg_ev);
    if (qz_ev)                         return CAL_PRECISE;
    if (msg_ev && s == CAL_NONE)       return CAL_BASIC;
    if (tmo && s == CAL_PRECISE)       return CAL_BASIC;
    if (tmo)                           return CAL_NONE;
    return s;
  endfunction

endpackage

// File: rtl/calw_fall_det.sv
module calw_fall_det (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic fall_o
);
  logic line_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= 1'b1;
    else        line_q <= line_i;
  end

  assign fall_o = line_q & ~line_i;
endmodule

// File: rtl/calw_counter.sv
module calw_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          armed_i,
  input  logic          run_i,
  input  logic          restart_i,
  input  logic          tick_i,
  input  logic [CW-1:0] reload_i,
  output logic [CW-1:0] cnt_o,
  output logic          tmo_o
);
  logic [CW-1:0] cnt_q;

  // Next count: parked on reload while disarmed, frozen while paused.
  function automatic logic [CW-1:0] cnt_step(logic [CW-1:0] c, logic [CW-1:0] rl,
                                              logic arm, logic run, logic rld,
                                              logic tick);
    if (!arm)                 return rl;
    if (!run)                 return c;
    if (rld)                  return rl;
    if (tick && c != '0)      return c - 1'b1;
    return c;
  endfunction

  assign tmo_o = armed_i & run_i & ~restart_i & (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_step(cnt_q, reload_i, armed_i, run_i,
                                  restart_i | tmo_o, tick_i);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/calw_fsm.sv
module calw_fsm
  import calw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_i,
  input  logic       fall_i,
  input  logic       msg_i,
  input  logic       qz_i,
  input  logic       tmo_i,
  output cal_state_e state_o,
  output logic       armed_o,
  output logic       restart_o,
  output logic       changed_o
);
  cal_state_e state_q, state_nx;
  logic       armed_q;
  logic       qz_ev, msg_ev;

  assign qz_ev     = run_i & armed_q & qz_i;
  assign msg_ev    = run_i & armed_q & msg_i;
  assign restart_o = qz_ev | (msg_ev & (state_q != CAL_PRECISE));
  assign state_nx  = cal_next(state_q, tmo_i, qz_ev, msg_ev);
  assign changed_o = run_i & (state_nx != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CAL_NONE;
      armed_q <= 1'b0;
    end else if (run_i) begin
      state_q <= state_nx;
      if (tmo_i && state_nx == CAL_NONE) armed_q <= 1'b0;
      else if (state_nx != CAL_NONE)     armed_q <= 1'b1;
      else if (fall_i)                   armed_q <= 1'b1;
    end
  end

  assign state_o = state_q;
  assign armed_o = armed_q;
endmodule

// File: rtl/calib_watchdog.sv
module calib_watchdog
  import calw_pkg::*;
#(
  parameter int CW = 16,
  parameter int DW = 32,
  parameter int NF = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_line,
  input  logic          msg_rx,
  input  logic          qz_rx,
  input  logic          eng_init,
  input  logic          tick_en,
  input  logic          reg_wen,
  input  logic [1:0]    reg_addr,
  input  logic [CW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq
);
  localparam int SW = 2;

  cal_state_e    state_q;
  logic          armed_q, restart_ev, tmo_ev, fall_ev, changed_ev, run;
  logic [CW-1:0] cnt_q, reload_q;
  logic [NF-1:0] flag_q, en_q, flag_set;
  logic          wr_reload, wr_flag, wr_en;

  assign run       = ~eng_init;
  assign wr_reload = reg_wen & (reg_addr == REG_WDOG);
  assign wr_flag   = reg_wen & (reg_addr == REG_FLAG);
  assign wr_en     = reg_wen & (reg_addr == REG_ENAB);

  calw_fall_det fall_i (
    .clk(clk), .rst_n(rst_n), .line_i(rx_line), .fall_o(fall_ev)
  );

  calw_fsm fsm_i (
    .clk(clk), .rst_n(rst_n), .run_i(run), .fall_i(fall_ev), .msg_i(msg_rx),
    .qz_i(qz_rx), .tmo_i(tmo_ev), .state_o(state_q), .armed_o(armed_q),
    .restart_o(restart_ev), .changed_o(changed_ev)
  );

  calw_counter #(.CW(CW)) cnt_i (
    .clk(clk), .rst_n(rst_n), .armed_i(armed_q), .run_i(run),
    .restart_i(restart_ev), .tick_i(tick_en), .reload_i(reload_q),
    .cnt_o(cnt_q), .tmo_o(tmo_ev)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
      en_q     <= '0;
    end else begin
      if (wr_reload) reload_q <= reg_wdata;
      if (wr_en)     en_q     <= reg_wdata[NF-1:0];
    end
  end

  // Bit 0: timeout, bit 1: state change; further bits stay clear.
  always_comb begin
    flag_set    = '0;
    flag_set[0] = tmo_ev;
    flag_set[1] = changed_ev;
  end

  for (genvar g = 0; g < NF; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[g] <= 1'b0;
      else        flag_q[g] <= flag_set[g] | (flag_q[g] & ~(wr_flag & reg_wdata[g]));
    end
  end

  assign irq = |(flag_q & en_q);

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      REG_WDOG: reg_rdata[2*CW-1:0]   = {cnt_q, reload_q};
      REG_STAT: reg_rdata[DW-1 -: SW] = state_q;
      REG_FLAG: reg_rdata[NF-1:0]     = flag_q;
      default:  reg_rdata[NF-1:0]     = en_q;
    endcase
  end
endmodule

// File: rtl/calw_checker.sv
module calw_checker #(
  parameter int CW = 16,
  parameter int NF = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          eng_init,
  input logic          tick_en,
  input logic          reg_wen,
  input logic [1:0]    reg_addr,
  input logic          irq,
  input logic [1:0]    state_q,
  input logic [CW-1:0] cnt_q,
  input logic          armed_q,
  input logic          restart_ev,
  input logic          tmo_ev,
  input logic [NF-1:0] flag_q
);
  logic touch_irq_regs;
  assign touch_irq_regs = reg_wen & reg_addr[1];

  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != 2'b11); // R1

  AST_NONE_TMO_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_ev && state_q == 2'b00) |=> (state_q == 2'b00 && !armed_q)); // R3

  AST_BASIC_TMO_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_ev && state_q == 2'b01) |=> state_q == 2'b00); // R5

  AST_PRECISE_TMO_BASIC: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_ev && state_q == 2'b10) |=> state_q == 2'b01); // R7

  AST_INIT_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    eng_init |=> $stable(state_q)); // R8

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && armed_q && !eng_init && !restart_ev && !tmo_ev && cnt_q != '0)
      |=> cnt_q == CW'($past(cnt_q) - 1'b1)); // R9

  AST_TMO_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_ev |=> flag_q[0]); // R10

  AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !touch_irq_regs) |=> irq); // R11
endmodule

bind calib_watchdog calw_checker #(.CW(CW), .NF(NF)) chk_i (
  .clk(clk), .rst_n(rst_n), .eng_init(eng_init), .tick_en(tick_en),
  .reg_wen(reg_wen), .reg_addr(reg_addr), .irq(irq), .state_q(state_q),
  .cnt_q(cnt_q), .armed_q(armed_q), .restart_ev(restart_ev), .tmo_ev(tmo_ev),
  .flag_q(flag_q)
);

// File: tb/calib_watchdog_tb_top.sv
module calib_watchdog_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_line = 1'b1, msg_rx = 1'b0, qz_rx = 1'b0, eng_init = 1'b0;
  logic        tick_en = 1'b0, reg_wen = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int applied = 0;
  int miscompares = 0;

  always #10 clk = ~clk;

  calib_watchdog dut_i (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .msg_rx(msg_rx), .qz_rx(qz_rx),
    .eng_init(eng_init), .tick_en(tick_en), .reg_wen(reg_wen), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  typedef struct packed {
    logic        rx, msg, qz, init, tick, wen;
    logic [1:0]  addr;
    logic [15:0] wd;
    logic [1:0]  e_st;
    logic [15:0] e_cnt;
    logic [1:0]  e_fl;
    logic        e_irq;
  } vec_t;

  localparam int NV = 34;
  localparam vec_t VECS [NV] = '{
    //  rx   msg  qz   init tick wen  addr  wd      st     cnt     fl     irq
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,2'd0,16'd4,2'd0,16'd0,2'd0,1'b0}, // 0  R2 reload write
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,2'd3,16'd3,2'd0,16'd4,2'd0,1'b0}, // 1  R2 count follows reload
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,2'd0,16'd0,2'd0,16'd4,2'd0,1'b0}, // 2  R2 not armed
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,16'd0,2'd0,16'd4,2'd0,1'b0}, // 3  R2 falling edge arms
    '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,2'd0,16'd0,2'd0,16'd3,2'd0,1'b0}, // 4  R9
    '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,2'd0,16'd0,2'd0,16'd2,2'd0,1'b0}, // 5  R9
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,2'd0,16'd0,2'd1,16'd4,2'd2,1'b1}, // 6  R4 R1 R10
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'd2,16'd2,2'd1,16'd4,2'd0,1'b0}, // 7  R10 clear
    '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,2'd0,16'd0,2'd1,16'd3,2'd0,1'b0}, // 8  R9
    '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,2'd0,16'd0,2'd1,16'd2,2'd0,1'b0}, // 9
    '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,2'd0,16'd0,2'd1,16'd1,2'd0,1'b0}, // 10
    '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,2'd0,16'd0,2'd1,16'd0,2'd0,1'b0}, // 11
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,16'd0,2'd0,16'd4,2'd3,1'b1}, // 12 R5 timeout
    '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,2'd2,16'd3,2'd0,16'd4,2'd0,1'b0}, // 13 R5 disarmed
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,16'd0,2'd0,16'd4,2'd0,1'b0}, // 14
    '{1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,2'd0,16'd0,2'd0,16'd4,2'd0,1'b0}, // 15 R8 edge lost
    '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,2'd0,16'd0,2'd0,16'd4,2'd0,1'b0}, // 16 R8 still parked
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,16'd0,2'd0,16'd4,2'd0,1'b0}, // 17
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,16'd0,2'd0,16'd4,2'd0,1'b0}, // 18 R2 arm
    '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,2'd0,16'd0,2'd2,16'd4,2'd2,1'b1}, // 19 R6 precision
    '{1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,2'd0,16'd0,2'd2,16'd3,2'd2,1'b1}, // 20 R6 msg no restart
    '{1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,2'd0,16'd0,2'd2,16'd3,2'd2,1'b1}, // 21 R8 paused
    '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,2'd0,16'd0,2'd2,16'd2,2'd2,1'b1}, // 22
    '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,2'd0,16'd0,2'd2,16'd1,2'd2,1'b1}, // 23
    '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,2'd0,16'd0,2'd2,16'd0,2'd2,1'b1}, // 24 R9 no wrap
    '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,2'd0,16'd0,2'd1,16'd4,2'd3,1'b1}, // 25 R7
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'd0,16'd0,2'd1,16'd4,2'd3,1'b1}, // 26 reload 0
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,2'd0,16'd0,2'd1,16'd0,2'd3,1'b1}, // 27 R5 restart
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,16'd0,2'd0,16'd0,2'd3,1'b1}, // 28 R9 zero timeout
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'd2,16'd0,2'd0,16'd0,2'd3,1'b1}, // 29 R10 write 0
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'd2,16'd1,2'd0,16'd0,2'd2,1'b1}, // 30 R10 clear bit 0
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'd3,16'd0,2'd0,16'd0,2'd2,1'b0}, // 31 R11
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'd3,16'd1,2'd0,16'd0,2'd2,1'b0}, // 32 R11 mismatch
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'd3,16'd2,2'd0,16'd0,2'd2,1'b1}  // 33 R11 match
  };

  task automatic drive(input vec_t v);
    rx_line = v.rx; msg_rx = v.msg; qz_rx = v.qz; eng_init = v.init;
    tick_en = v.tick; reg_wen = v.wen; reg_addr = v.addr; reg_wdata = v.wd;
    @(posedge clk);
    @(negedge clk);
    reg_wen = 1'b0; msg_rx = 1'b0; qz_rx = 1'b0; tick_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic observe(output logic [1:0] st, output logic [15:0] cnt,
                         output logic [15:0] rl, output logic [1:0] fl,
                         output logic [3:0] low_stat);
    logic [31:0] d;
    rd(2'd0, d); cnt = d[31:16]; rl = d[15:0];
    rd(2'd1, d); st = d[31:30]; low_stat = d[3:0] | {2'b00, d[29:28]};
    rd(2'd2, d); fl = d[1:0];
  endtask

  function automatic vec_t mk(logic rx, logic msg, logic tick, logic wen,
                              logic [1:0] a, logic [15:0] wd);
    vec_t v = '0;
    v.rx = rx; v.msg = msg; v.tick = tick; v.wen = wen; v.addr = a; v.wd = wd;
    return v;
  endfunction

  initial begin
    #4_000_000;
    miscompares++;
    $display("FAIL watchdog expired: actual running, expected finished");
    $display("  == %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

  initial begin
    logic [1:0]  st, fl;
    logic [15:0] cnt, rl;
    logic [3:0]  ls;
    logic [31:0] d;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 / R1: reset state
    observe(st, cnt, rl, fl, ls);
    rd(2'd3, d);
    applied++;
    if (st != 2'd0 || cnt != 0 || rl != 0 || fl != 0 || d != 0 || irq != 1'b0 || ls != 0) begin
      miscompares++;
      $display("FAIL R12 reset: st=%0d cnt=%0d rl=%0d fl=%0d en=%0h irq=%0b expected all 0",
               st, cnt, rl, fl, d, irq);
    end

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      observe(st, cnt, rl, fl, ls);
      applied++;
      if (st != VECS[i].e_st || cnt != VECS[i].e_cnt || fl != VECS[i].e_fl ||
          irq != VECS[i].e_irq || ls != 0) begin
        miscompares++;
        $display("FAIL vector %0d (R1-tagged table): st=%0d cnt=%0d fl=%0d irq=%0b expected st=%0d cnt=%0d fl=%0d irq=%0b",
                 i, st, cnt, fl, irq, VECS[i].e_st, VECS[i].e_cnt, VECS[i].e_fl, VECS[i].e_irq);
      end
    end

    // R12: reset in the middle of activity
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    observe(st, cnt, rl, fl, ls);
    rd(2'd3, d);
    applied++;
    if (st != 0 || cnt != 0 || rl != 0 || fl != 0 || d != 0 || irq != 0) begin
      miscompares++;
      $display("FAIL R12 mid-run reset: st=%0d cnt=%0d rl=%0d fl=%0d en=%0h irq=%0b expected all 0",
               st, cnt, rl, fl, d, irq);
    end

    // R10 / R3: a timeout in the not-calibrated state meets a clear of bit 0
    drive(mk(1'b1, 1'b0, 1'b0, 1'b1, 2'd0, 16'd1)); // reload 1
    drive(mk(1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 16'd0));
    drive(mk(1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 16'd0)); // arm, count 1
    drive(mk(1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 16'd0)); // count 0
    observe(st, cnt, rl, fl, ls);
    applied++;
    if (cnt != 16'd0 || rl != 16'd1) begin
      miscompares++;
      $display("FAIL R2 reload/count fields: cnt=%0d rl=%0d expected cnt=0 rl=1", cnt, rl);
    end
    drive(mk(1'b0, 1'b0, 1'b0, 1'b1, 2'd2, 16'd1)); // timeout + clear together
    observe(st, cnt, rl, fl, ls);
    applied++;
    if (fl != 2'b01 || st != 2'd0 || cnt != 16'd1) begin
      miscompares++;
      $display("FAIL R10 set beats clear: fl=%0d st=%0d cnt=%0d expected fl=1 st=0 cnt=1",
               fl, st, cnt);
    end
    // R3: disarmed after the timeout, ticks have no effect until a new edge
    for (int k = 0; k < 3; k++) drive(mk(1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 16'd0));
    observe(st, cnt, rl, fl, ls);
    applied++;
    if (cnt != 16'd1 || st != 2'd0 || fl != 2'b01) begin
      miscompares++;
      $display("FAIL R3 parked after timeout: cnt=%0d st=%0d fl=%0d expected cnt=1 st=0 fl=1",
               cnt, st, fl);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end
endmodule